// File: doc/BRIEF.md
# Windowed RGB Pixel Streamer

This block feeds a colour display panel through a four-wire serial front end. The serializer is not part of it. When a start request arrives, the block latches a rectangular region given by first and last column and first and last row. It then emits a short address-window preamble: a row-range opcode, a column-range opcode and a memory-write opcode. Each opcode is marked as a command byte, and its coordinate arguments are marked as data bytes.

After the preamble the block accepts 32-bit source pixels on a valid/ready port. It reduces each pixel to three bytes that carry only 6 significant bits each and sends them as data. Rows follow each other in ascending order, with no further commands between them. For a panel mounted upside down, a flip input moves both row addresses in the preamble down the controller's row space.

The output is a byte plus a command/data flag, with valid/ready flow control. A single-cycle done pulse marks the end of the region.

Top module: `rgb_window_streamer`

## Requirements
- R1: After reset `out_valid_o`, `pix_ready_o`, `busy_o` and `done_o` are all low.
- R2: A transfer begins with exactly seven bytes, where flag `out_is_data_o` is 0 for command and 1 for data:
  - command `OP_ROW` (default 0x75), then data first row, then data last row;
  - command `OP_COL` (default 0x15), then data first column, then data last column;
  - command `OP_WR` (default 0x5C).
- R3: With the default lane order, each accepted pixel yields three data bytes: bits [7:0], then [15:8], then [23:16], each shifted right by 2. Bits [31:24] have no effect on the output.
- R4: `pix_ready_o` stays low while a command byte or any other preamble byte is being offered.
- R5: Rows go out from the first row to the last row inclusive. Each row carries 3 × (last column − first column + 1) data bytes, for widths up to `MAX_COLS` (160), and no command byte appears after the preamble.
- R6: With flip set at start, both row bytes in the preamble equal row + (`FLIP_BASE` − `PANEL_H`) modulo 256, which is +4 by default. Columns are never altered, and with flip clear the rows are sent as given.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the next cycle presents the same byte and flag, and `pix_ready_o` is low.
- R8: `done_o` is high for exactly one cycle, in the cycle after the handshake of the final byte. `busy_o` is low in that same cycle.
- R9: A start request while `busy_o` is high is ignored. The region, flip setting and byte stream of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| flip_i | input | 1 | Panel mounted upside down, latched at start |
| col_first_i | input | 8 | First column of the region |
| col_last_i | input | 8 | Last column of the region |
| row_first_i | input | 8 | First row of the region |
| row_last_i | input | 8 | Last row of the region |
| pix_valid_i | input | 1 | Source pixel valid |
| pix_ready_o | output | 1 | Source pixel accepted this cycle when valid |
| pix_data_i | input | 32 | Source pixel, four byte lanes |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Serializer ready for a byte |
| out_byte_o | output | 8 | Output byte |
| out_is_data_o | output | 1 | 1 = data byte, 0 = command byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-region pulse |

## Verification
The bench drives five regions:
- a single-pixel window;
- a full 160-pixel-wide window;
- a multi-row window;
- a flipped window whose shifted rows wrap past 255;
- a transfer hit by a second start request with different coordinates.

Both valid and ready are throttled across these regions. A packer that reloads too early would duplicate or skip a pixel at a stall. A wrong lane order, or a missing shift, would corrupt every data byte. A row counter that is off by one would lengthen or shorten the stream, and that shows up as an orphan byte or a done pulse with bytes still expected. A design that accepts the mid-transfer start would restart the preamble, which the scoreboard sees as an unexpected command byte.

// File: rtl/win_pkg.sv
package win_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PIX  = 2'd2
   } wstate_t;

   localparam int HDR_LEN   = 7;
   localparam int HDR_IDX_W = 3;
   localparam int LANES     = 3;
endpackage

// File: rtl/win_hdr_seq.sv
module win_hdr_seq
   import win_pkg::*;
#(
   parameter int COORD_W = 8,
   parameter int BYTE_W  = 8,
   parameter logic [BYTE_W-1:0] OP_ROW = 8'h75,
   parameter logic [BYTE_W-1:0] OP_COL = 8'h15,
   parameter logic [BYTE_W-1:0] OP_WR  = 8'h5C,
   parameter logic [COORD_W-1:0] ROW_SHIFT = 4
) (
   input  logic [HDR_IDX_W-1:0] idx_i,
   input  logic                 flip_i,
   input  logic [COORD_W-1:0]   col_a_i,
   input  logic [COORD_W-1:0]   col_b_i,
   input  logic [COORD_W-1:0]   row_a_i,
   input  logic [COORD_W-1:0]   row_b_i,
   output logic [BYTE_W-1:0]    byte_o,
   output logic                 is_data_o,
   output logic                 last_o
);
   logic [COORD_W-1:0] row_a_adj, row_b_adj;

   // flip moves both row addresses; wraps modulo the coordinate width
   assign row_a_adj = flip_i ? row_a_i + ROW_SHIFT : row_a_i;
   assign row_b_adj = flip_i ? row_b_i + ROW_SHIFT : row_b_i;

   always_comb begin
      byte_o    = '0;
      is_data_o = 1'b1;
      case (idx_i)
         3'd0: begin byte_o = OP_ROW; is_data_o = 1'b0; end
         3'd1: byte_o = BYTE_W'(row_a_adj);
         3'd2: byte_o = BYTE_W'(row_b_adj);
         3'd3: begin byte_o = OP_COL; is_data_o = 1'b0; end
         3'd4: byte_o = BYTE_W'(col_a_i);
         3'd5: byte_o = BYTE_W'(col_b_i);
         default: begin byte_o = OP_WR; is_data_o = 1'b0; end
      endcase
   end

   assign last_o = (idx_i == HDR_IDX_W'(HDR_LEN - 1));
endmodule

// File: rtl/win_px_pack.sv
module win_px_pack
   import win_pkg::*;
#(
   parameter int PIX_W         = 32,
   parameter int BYTE_W        = 8,
   parameter int KEEP_BITS     = 6,
   parameter bit SRC_LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic              take_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              last_o
);
   localparam int SHIFT = BYTE_W - KEEP_BITS;

   logic [BYTE_W-1:0] lane_in [LANES];
   logic [BYTE_W-1:0] lane_q  [LANES];
   logic [1:0]        sub_q;
   logic              full_q;
   logic [BYTE_W-1:0] dropped_lane;
   logic              pk_unused;

   generate
      if (SRC_LSB_FIRST) begin : g_lsb
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_in[k] = pix_i[k*BYTE_W +: BYTE_W] >> SHIFT;
         end
         assign dropped_lane = pix_i[PIX_W-1 -: BYTE_W];
      end else begin : g_msb
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_in[k] = pix_i[PIX_W-1-k*BYTE_W -: BYTE_W] >> SHIFT;
         end
         assign dropped_lane = pix_i[BYTE_W-1:0];
      end
   endgenerate

   // the fourth lane and low shifted-out bits carry no meaning downstream
   assign pk_unused = ^dropped_lane;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         sub_q  <= '0;
         for (int k = 0; k < LANES; k++) lane_q[k] <= '0;
      end else if (load_i) begin
         full_q <= 1'b1;
         sub_q  <= '0;
         for (int k = 0; k < LANES; k++) lane_q[k] <= lane_in[k];
      end else if (take_i) begin
         if (sub_q == 2'(LANES - 1)) full_q <= 1'b0;
         else                        sub_q  <= sub_q + 2'd1;
      end
   end

   assign valid_o = full_q;
   assign byte_o  = lane_q[sub_q];
   assign last_o  = (sub_q == 2'(LANES - 1));

   a_r3_msbs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> (byte_o >> KEEP_BITS) == '0)
      else $error("R3: packed lane keeps bits above the panel depth");
endmodule

// File: rtl/win_count.sv
module win_count #(
   parameter int COORD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_i,
   input  logic               step_i,
   input  logic [COORD_W-1:0] col_a_i,
   input  logic [COORD_W-1:0] col_b_i,
   input  logic [COORD_W-1:0] row_a_i,
   input  logic [COORD_W-1:0] row_b_i,
   output logic               all_in_o
);
   logic [COORD_W-1:0] col_q, row_q, col_start_q;
   logic               all_in_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q       <= '0;
         row_q       <= '0;
         col_start_q <= '0;
         all_in_q    <= 1'b0;
      end else if (init_i) begin
         col_q       <= col_a_i;
         row_q       <= row_a_i;
         col_start_q <= col_a_i;
         all_in_q    <= 1'b0;
      end else if (step_i) begin
         if (col_q == col_b_i) begin
            col_q <= col_start_q;
            if (row_q == row_b_i) all_in_q <= 1'b1;
            else                  row_q    <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   assign all_in_o = all_in_q;

   a_r5_no_step_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      all_in_q |-> !step_i)
      else $error("R5: pixel accepted past the end of the region");
endmodule

// File: rtl/rgb_window_streamer.sv
module rgb_window_streamer
   import win_pkg::*;
#(
   parameter int COORD_W       = 8,
   parameter int BYTE_W        = 8,
   parameter int PIX_W         = 32,
   parameter int KEEP_BITS     = 6,
   parameter int PANEL_H       = 128,
   parameter int FLIP_BASE     = 132,
   parameter int MAX_COLS      = 160,
   parameter bit SRC_LSB_FIRST = 1'b1,
   parameter logic [BYTE_W-1:0] OP_ROW = 8'h75,
   parameter logic [BYTE_W-1:0] OP_COL = 8'h15,
   parameter logic [BYTE_W-1:0] OP_WR  = 8'h5C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               flip_i,
   input  logic [COORD_W-1:0] col_first_i,
   input  logic [COORD_W-1:0] col_last_i,
   input  logic [COORD_W-1:0] row_first_i,
   input  logic [COORD_W-1:0] row_last_i,
   input  logic               pix_valid_i,
   output logic               pix_ready_o,
   input  logic [PIX_W-1:0]   pix_data_i,
   output logic               out_valid_o,
   input  logic               out_ready_i,
   output logic [BYTE_W-1:0]  out_byte_o,
   output logic               out_is_data_o,
   output logic               busy_o,
   output logic               done_o
);
   localparam logic [COORD_W-1:0] ROW_SHIFT = COORD_W'(FLIP_BASE - PANEL_H);

   generate
      if (PANEL_H > FLIP_BASE) begin : g_bad_height
         $error("PANEL_H must not exceed FLIP_BASE");
      end
      if (MAX_COLS > (1 << COORD_W)) begin : g_bad_cols
         $error("MAX_COLS does not fit the coordinate width");
      end
      if (PIX_W < LANES * BYTE_W + 1) begin : g_bad_pix
         $error("PIX_W must hold three lanes plus a discarded lane");
      end
      if (KEEP_BITS > BYTE_W) begin : g_bad_keep
         $error("KEEP_BITS wider than a byte");
      end
   endgenerate

   wstate_t              state_q;
   logic [HDR_IDX_W-1:0] idx_q;
   logic [COORD_W-1:0]   ca_q, cb_q, ra_q, rb_q;
   logic                 flip_q, done_q;

   logic [BYTE_W-1:0] hdr_byte, pk_byte;
   logic              hdr_is_data, hdr_last;
   logic              pk_valid, pk_last, all_in;
   logic              pix_load, pk_take, finish, init;

   win_hdr_seq #(
      .COORD_W(COORD_W), .BYTE_W(BYTE_W),
      .OP_ROW(OP_ROW), .OP_COL(OP_COL), .OP_WR(OP_WR),
      .ROW_SHIFT(ROW_SHIFT)
   ) u_hdr (
      .idx_i(idx_q), .flip_i(flip_q),
      .col_a_i(ca_q), .col_b_i(cb_q), .row_a_i(ra_q), .row_b_i(rb_q),
      .byte_o(hdr_byte), .is_data_o(hdr_is_data), .last_o(hdr_last)
   );

   win_px_pack #(
      .PIX_W(PIX_W), .BYTE_W(BYTE_W), .KEEP_BITS(KEEP_BITS),
      .SRC_LSB_FIRST(SRC_LSB_FIRST)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .load_i(pix_load), .pix_i(pix_data_i),
      .take_i(pk_take), .valid_o(pk_valid), .byte_o(pk_byte), .last_o(pk_last)
   );

   win_count #(.COORD_W(COORD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .init_i(init), .step_i(pix_load),
      .col_a_i(col_first_i), .col_b_i(cb_q),
      .row_a_i(row_first_i), .row_b_i(rb_q),
      .all_in_o(all_in)
   );

   assign init        = (state_q == ST_IDLE) && start_i;
   assign pix_ready_o = (state_q == ST_PIX) && !all_in &&
                        (!pk_valid || (pk_last && out_ready_i));
   assign pix_load    = pix_valid_i && pix_ready_o;
   assign pk_take     = (state_q == ST_PIX) && pk_valid && out_ready_i;
   assign finish      = pk_take && pk_last && all_in;

   always_comb begin
      out_valid_o   = 1'b0;
      out_byte_o    = '0;
      out_is_data_o = 1'b0;
      if (state_q == ST_HDR) begin
         out_valid_o   = 1'b1;
         out_byte_o    = hdr_byte;
         out_is_data_o = hdr_is_data;
      end else if (state_q == ST_PIX) begin
         out_valid_o   = pk_valid;
         out_byte_o    = pk_byte;
         out_is_data_o = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         ca_q    <= '0;
         cb_q    <= '0;
         ra_q    <= '0;
         rb_q    <= '0;
         flip_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               ca_q    <= col_first_i;
               cb_q    <= col_last_i;
               ra_q    <= row_first_i;
               rb_q    <= row_last_i;
               flip_q  <= flip_i;
               idx_q   <= '0;
               state_q <= ST_HDR;
            end
            ST_HDR: if (out_ready_i) begin
               if (hdr_last) state_q <= ST_PIX;
               else          idx_q   <= idx_q + 1'b1;
            end
            ST_PIX: if (finish) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;

   a_r4_cmd_blocks_source: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_is_data_o) |-> !pix_ready_o)
      else $error("R4: source ready during preamble");

   a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=>
         (out_valid_o && $stable(out_byte_o) && $stable(out_is_data_o)))
      else $error("R7: output changed under stall");

   a_r7_stall_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |-> !pix_ready_o)
      else $error("R7: source ready while output stalled");

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("R8: done longer than one cycle");

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o)
      else $error("R8: busy still high with done");

   a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i))
      else $error("R9: transfer began without a start request");
endmodule

// File: tb/rgb_window_streamer_test.sv
module rgb_window_streamer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, flip_i = 1'b0;
   logic [7:0]  col_first_i = '0, col_last_i = '0, row_first_i = '0, row_last_i = '0;
   logic        pix_valid_i = 1'b0;
   logic [31:0] pix_data_i = '0;
   logic        out_ready_i = 1'b0;
   logic        pix_ready_o, out_valid_o, out_is_data_o, busy_o, done_o;
   logic [7:0]  out_byte_o;

   rgb_window_streamer uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .flip_i(flip_i),
      .col_first_i(col_first_i), .col_last_i(col_last_i),
      .row_first_i(row_first_i), .row_last_i(row_last_i),
      .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o), .pix_data_i(pix_data_i),
      .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_byte_o(out_byte_o),
      .out_is_data_o(out_is_data_o), .busy_o(busy_o), .done_o(done_o)
   );

   always #5 clk = ~clk;

   int checks = 0, failures = 0;
   int cyc = 0, done_cnt = 0;
   int rmode = 0, vmode = 0;
   logic        run_en = 1'b0;
   logic [8:0]  exp_q[$];
   logic [31:0] src_q[$];
   logic        stall_seen = 1'b0;
   logic [8:0]  stall_val = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pix_val(input int seed, input int i);
      return (32'(seed) * 32'h01000193) ^ (32'(i) * 32'h9E3779B9) ^ 32'hA5000000;
   endfunction

   // monitor / scoreboard and stimulus for both streaming ports
   always @(negedge clk) begin
      cyc++;
      if (run_en) begin
         case (rmode)
            0: out_ready_i = 1'b1;
            1: out_ready_i = (cyc % 3) != 0;
            default: out_ready_i = (cyc % 5) < 2;
         endcase
         pix_valid_i = (src_q.size() > 0) && (vmode == 0 || (cyc % 4) != 1);
         pix_data_i  = (src_q.size() > 0) ? src_q[0] : 32'h0;
      end
      #1;
      if (stall_seen) begin
         chk(out_valid_o && ({out_is_data_o, out_byte_o} == stall_val),
             "R7 stalled byte held", {out_is_data_o, out_byte_o}, stall_val);
      end
      stall_seen = 1'b0;
      if (out_valid_o && !out_ready_i) begin
         stall_seen = 1'b1;
         stall_val  = {out_is_data_o, out_byte_o};
         chk(!pix_ready_o, "R7 source ready under stall", pix_ready_o, 0);
      end
      if (out_valid_o && !out_is_data_o)
         chk(!pix_ready_o, "R4 source ready during preamble", pix_ready_o, 0);
      if (out_valid_o && out_ready_i) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected extra byte", {out_is_data_o, out_byte_o}, 0);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk({out_is_data_o, out_byte_o} == e, "R2/R3/R5/R6 stream byte",
                {out_is_data_o, out_byte_o}, e);
         end
      end
      if (pix_valid_i && pix_ready_o) void'(src_q.pop_front());
      if (done_o) begin
         done_cnt++;
         chk(exp_q.size() == 0, "R8 done with bytes outstanding", exp_q.size(), 0);
         chk(!busy_o, "R8 busy low with done", busy_o, 0);
      end
   end

   task automatic run_window(input int c0, input int c1, input int r0, input int r1,
                             input bit flip, input int seed, input int rm, input int vm,
                             input bit inject);
      int n = 0;
      int d0;
      d0 = done_cnt;
      exp_q.push_back({1'b0, 8'h75});
      exp_q.push_back({1'b1, flip ? 8'(r0 + 4) : 8'(r0)});
      exp_q.push_back({1'b1, flip ? 8'(r1 + 4) : 8'(r1)});
      exp_q.push_back({1'b0, 8'h15});
      exp_q.push_back({1'b1, 8'(c0)});
      exp_q.push_back({1'b1, 8'(c1)});
      exp_q.push_back({1'b0, 8'h5C});
      for (int r = r0; r <= r1; r++) begin
         for (int c = c0; c <= c1; c++) begin
            logic [31:0] p;
            p = pix_val(seed, n);
            n++;
            src_q.push_back(p);
            exp_q.push_back({1'b1, p[7:0] >> 2});
            exp_q.push_back({1'b1, p[15:8] >> 2});
            exp_q.push_back({1'b1, p[23:16] >> 2});
         end
      end
      @(negedge clk);
      rmode = rm; vmode = vm;
      col_first_i = 8'(c0); col_last_i = 8'(c1);
      row_first_i = 8'(r0); row_last_i = 8'(r1);
      flip_i = flip; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (inject) begin
         repeat (30) @(negedge clk);
         col_first_i = 8'd1; col_last_i = 8'd2; row_first_i = 8'd9;
         row_last_i = 8'd9; flip_i = ~flip; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         #2;
         chk(busy_o, "R9 busy kept after ignored start", busy_o, 1);
      end
      wait (done_cnt > d0);
      repeat (4) @(negedge clk);
      #2;
      chk(done_cnt == d0 + 1, "R8 single done pulse", done_cnt - d0, 1);
      chk(src_q.size() == 0, "R5 all pixels consumed", src_q.size(), 0);
      chk(exp_q.size() == 0, "R5 all bytes emitted", exp_q.size(), 0);
      chk(!busy_o && !out_valid_o, "R8 idle after region", {busy_o, out_valid_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk(!out_valid_o, "R1 out_valid after reset", out_valid_o, 0);
      chk(!pix_ready_o, "R1 pix_ready after reset", pix_ready_o, 0);
      chk(!busy_o, "R1 busy after reset", busy_o, 0);
      chk(!done_o, "R1 done after reset", done_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      run_en = 1'b1;
      run_window(2, 4, 1, 2, 1'b0, 11, 0, 0, 1'b0);     // R2 R3 basic
      run_window(7, 7, 9, 9, 1'b1, 23, 1, 0, 1'b0);     // R6 single pixel, flipped
      run_window(0, 1, 254, 255, 1'b1, 37, 2, 1, 1'b0); // R6 wrap past 255
      run_window(0, 159, 5, 6, 1'b0, 41, 1, 1, 1'b1);   // R5 full width, R9 start ignored
      run_window(10, 12, 3, 5, 1'b0, 59, 2, 0, 1'b0);   // R5 multi-row, R7 stalls
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired checks pending=%0d expected=0", exp_q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule